// File: doc/BRIEF.md
# Dual-View Byte/Word Memory

This block is the data store of a small stack machine. A single array of bytes is seen through two windows. A byte fetch port takes a byte address and returns one byte, which suits an instruction stream. A word port takes a word index, scales it by four into a byte address, and reads or writes a 32-bit value. The value is stored with its most significant byte at the lowest address. A third port, a byte write port, fills the array with a program image while the system is being set up.

The array is built as four byte-wide lanes, one per byte position within a word. A word access touches one row in all four lanes. A byte access touches one lane. After every reset, a two-state controller sweeps zero into every row. The states are `ST_WIPE`, entered on reset, and `ST_RUN`. The controller leaves `ST_WIPE` for `ST_RUN` on the cycle it clears the last row, and it stays in `ST_RUN` until the next reset. Because of this sweep, bytes that were never written read as zero.

An access that reaches past the last byte is flagged as an error and changes nothing. Reads take one cycle. A read issued in the same cycle as a write to the same byte returns the old contents.

Top module: `dual_view_mem`

## Requirements
- R1: After reset the block spends exactly ceil(DEPTH_BYTES/4) cycles in `ST_WIPE` with `ready` low. During that time all requests are ignored: no `fetch_vld`, no `word_vld` and no `pre_err` appears.
- R2: Every byte that has not been written since the last reset reads as zero, on both the fetch port and the word port.
- R3: A word write to index i stores bits 31:24 at byte 4i, bits 23:16 at 4i+1, bits 15:8 at 4i+2 and bits 7:0 at 4i+3.
- R4: A word read of index i returns byte 4i in bits 31:24, down to byte 4i+3 in bits 7:0. The data appears together with `word_vld` one cycle after the request.
- R5: A fetch returns the byte at `fetch_addr`, together with `fetch_vld`, one cycle after the request.
- R6: A fetch with `fetch_addr` >= DEPTH_BYTES raises `fetch_err`, and `fetch_byte` reads 0.
- R7: A word access with 4i+3 >= DEPTH_BYTES raises `word_err`. On such a read `word_rdata` is 0. On such a write no byte changes, not even the bytes of that row that lie within range.
- R8: A preload writes `pre_data` to `pre_addr`. A preload with `pre_addr` >= DEPTH_BYTES raises `pre_err` one cycle later and writes nothing.
- R9: A word read or a fetch issued in the same cycle as a word write to an overlapping byte returns the data from before the write.
- R10: A preload in the same cycle as an accepted word write is dropped. This holds whatever byte the preload targets.
- R11: Once `ready` rises it stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts the zero sweep |
| ready | output | 1 | High in `ST_RUN` |
| fetch_en | input | 1 | Byte fetch request |
| fetch_addr | input | ADDR_W | Byte address of the fetch |
| fetch_vld | output | 1 | Fetch result present |
| fetch_err | output | 1 | Fetch address was out of range |
| fetch_byte | output | 8 | Fetched byte |
| word_rd | input | 1 | Word read request |
| word_wr | input | 1 | Word write request |
| word_idx | input | ADDR_W | Word index; byte address is four times this |
| word_wdata | input | 32 | Word write data |
| word_vld | output | 1 | Word operation completed |
| word_err | output | 1 | Word access was out of range |
| word_rdata | output | 32 | Word read data |
| pre_en | input | 1 | Preload byte write |
| pre_addr | input | ADDR_W | Preload byte address |
| pre_data | input | 8 | Preload byte |
| pre_err | output | 1 | Preload address was out of range |

## Verification
The bench builds the block with DEPTH_BYTES = 22 and ADDR_W = 8. With these values the sweep lasts only six cycles, and every byte can be read and compared against a model kept in the bench. Because 22 is not a multiple of four, the last row is only half populated. This lets the bench show that a word access straddling the end is refused, while the two in-range bytes of that row keep their values. The 8-bit addresses also reach far past the end of the array, so the bench can exercise the range checks on all three ports.

// File: rtl/dvmem_pkg.sv
package dvmem_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = BYTE_W * LANES;

    typedef enum logic [0:0] {
        ST_WIPE = 1'b0,
        ST_RUN  = 1'b1
    } dvmem_state_e;
endpackage

// File: rtl/dvmem_bank.sv
// One byte lane: single write port, two registered read ports (read-before-write).
module dvmem_bank #(
    parameter int ROWS = 8,
    parameter int RW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [RW-1:0] wrow,
    input  logic [7:0]    wdata,
    input  logic          f_en,
    input  logic [RW-1:0] f_row,
    output logic [7:0]    f_q,
    input  logic          w_en,
    input  logic [RW-1:0] w_row,
    output logic [7:0]    w_q
);
    logic [7:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wrow] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
            w_q <= '0;
        end else begin
            if (f_en) begin
                f_q <= mem[f_row];
            end
            if (w_en) begin
                w_q <= mem[w_row];
            end
        end
    end
endmodule

// File: rtl/dvmem_ctrl.sv
// Reset sweep controller: clears one row per cycle, then enters run state.
module dvmem_ctrl
    import dvmem_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int RW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          ready,
    output logic          wipe_we,
    output logic [RW-1:0] wipe_row
);
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

    dvmem_state_e state, state_nx;
    logic [RW-1:0] cnt;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WIPE: if (cnt == LAST_ROW) state_nx = ST_RUN;
            ST_RUN:  state_nx = ST_RUN;
            default: state_nx = ST_WIPE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WIPE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state == ST_WIPE && cnt != LAST_ROW) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        ready    = 1'b0;
        wipe_we  = 1'b0;
        wipe_row = cnt;
        unique case (state)
            ST_WIPE: wipe_we = 1'b1;
            ST_RUN:  ready   = 1'b1;
            default: wipe_we = 1'b1;
        endcase
    end

    // R11
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R1
    wipe_row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_we |-> (32'(wipe_row) < ROWS));
endmodule

// File: rtl/dual_view_mem.sv
module dual_view_mem
    import dvmem_pkg::*;
#(
    parameter int DEPTH_BYTES = 5000,
    parameter int ADDR_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              ready,
    input  logic              fetch_en,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_vld,
    output logic              fetch_err,
    output logic [7:0]        fetch_byte,
    input  logic              word_rd,
    input  logic              word_wr,
    input  logic [ADDR_W-1:0] word_idx,
    input  logic [31:0]       word_wdata,
    output logic              word_vld,
    output logic              word_err,
    output logic [31:0]       word_rdata,
    input  logic              pre_en,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [7:0]        pre_data,
    output logic              pre_err
);
    localparam int ROWS = (DEPTH_BYTES + LANES - 1) / LANES;
    localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int XW   = ADDR_W + 2;
    localparam logic [XW-1:0] DEPTH_X = XW'(DEPTH_BYTES);

    logic          wipe_we;
    logic [RW-1:0] wipe_row;

    dvmem_ctrl #(.ROWS(ROWS), .RW(RW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ready    (ready),
        .wipe_we  (wipe_we),
        .wipe_row (wipe_row)
    );

    // Range decode for all three ports
    logic [XW-1:0] w_base, w_last;
    logic          f_oob, w_oob, p_oob;
    always_comb begin
        w_base = {word_idx, 2'b00};
        w_last = w_base + XW'(3);
        f_oob  = ({2'b00, fetch_addr} >= DEPTH_X);
        w_oob  = (w_last >= DEPTH_X);
        p_oob  = ({2'b00, pre_addr} >= DEPTH_X);
    end

    logic f_go, f_rd, w_go, w_rd_ok, w_wr_ok, p_wr;
    always_comb begin
        f_go    = ready & fetch_en;
        f_rd    = f_go & ~f_oob;
        w_go    = ready & (word_rd | word_wr);
        w_rd_ok = ready & word_rd & ~w_oob;
        w_wr_ok = ready & word_wr & ~w_oob;
        p_wr    = ready & pre_en & ~p_oob & ~w_wr_ok;
    end

    logic [RW-1:0] f_row, w_row, p_row;
    logic [1:0]    f_lane, p_lane;
    assign f_row  = fetch_addr[RW+1:2];
    assign f_lane = fetch_addr[1:0];
    assign w_row  = word_idx[RW-1:0];
    assign p_row  = pre_addr[RW+1:2];
    assign p_lane = pre_addr[1:0];

    logic [7:0] f_q [LANES];
    logic [7:0] w_q [LANES];

    // Lane g holds byte offset g of each word; offset 0 is the most significant byte.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic          b_we;
        logic [RW-1:0] b_row;
        logic [7:0]    b_wd;
        always_comb begin
            b_we  = wipe_we | w_wr_ok | (p_wr & (p_lane == 2'(g)));
            b_row = wipe_we ? wipe_row : (w_wr_ok ? w_row : p_row);
            b_wd  = wipe_we ? 8'h00 : (w_wr_ok ? word_wdata[31-8*g -: 8] : pre_data);
        end
        dvmem_bank #(.ROWS(ROWS), .RW(RW)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (b_we),
            .wrow  (b_row),
            .wdata (b_wd),
            .f_en  (f_rd & (f_lane == 2'(g))),
            .f_row (f_row),
            .f_q   (f_q[g]),
            .w_en  (w_rd_ok),
            .w_row (w_row),
            .w_q   (w_q[g])
        );
    end

    logic [1:0] f_lane_q;
    logic       f_err_q, w_err_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_lane_q  <= '0;
            f_err_q   <= 1'b0;
            w_err_q   <= 1'b0;
            fetch_vld <= 1'b0;
            word_vld  <= 1'b0;
            pre_err   <= 1'b0;
        end else begin
            fetch_vld <= f_go;
            word_vld  <= w_go;
            pre_err   <= ready & pre_en & p_oob;
            if (f_go) begin
                f_lane_q <= f_lane;
                f_err_q  <= f_oob;
            end
            if (w_go) begin
                w_err_q <= w_oob;
            end
        end
    end

    always_comb begin
        fetch_err  = f_err_q;
        word_err   = w_err_q;
        fetch_byte = f_err_q ? 8'h00 : f_q[f_lane_q];
        word_rdata = '0;
        if (!w_err_q) begin
            for (int k = 0; k < LANES; k++) begin
                word_rdata[31-8*k -: 8] = w_q[k];
            end
        end
    end

    // R1
    wipe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (!fetch_vld && !word_vld && !pre_err));

    // R5
    fetch_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && fetch_en) |=> fetch_vld);

    // R6
    fetch_oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && fetch_en && ({2'b00, fetch_addr} >= DEPTH_X))
            |=> (fetch_err && fetch_byte == 8'h00));

    // R7
    word_oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && word_rd && (({word_idx, 2'b00} + XW'(3)) >= DEPTH_X))
            |=> (word_vld && word_err && word_rdata == 32'h0));

    // R8
    pre_oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && pre_en && ({2'b00, pre_addr} >= DEPTH_X)) |=> pre_err);
endmodule

// File: tb/dual_view_mem_bench.sv
module dual_view_mem_bench;
    localparam int DEPTH = 22;
    localparam int AW    = 8;
    localparam int ROWS  = (DEPTH + 3) / 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ready;
    logic          fetch_en = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic          fetch_vld, fetch_err;
    logic [7:0]    fetch_byte;
    logic          word_rd = 1'b0, word_wr = 1'b0;
    logic [AW-1:0] word_idx = '0;
    logic [31:0]   word_wdata = '0;
    logic          word_vld, word_err;
    logic [31:0]   word_rdata;
    logic          pre_en = 1'b0;
    logic [AW-1:0] pre_addr = '0;
    logic [7:0]    pre_data = '0;
    logic          pre_err;

    int vectors = 0;
    int fails   = 0;
    logic [7:0] model [DEPTH];

    always #5 clk = ~clk;

    dual_view_mem #(.DEPTH_BYTES(DEPTH), .ADDR_W(AW)) u_dual_view_mem (
        .clk(clk), .rst_n(rst_n), .ready(ready),
        .fetch_en(fetch_en), .fetch_addr(fetch_addr), .fetch_vld(fetch_vld),
        .fetch_err(fetch_err), .fetch_byte(fetch_byte),
        .word_rd(word_rd), .word_wr(word_wr), .word_idx(word_idx),
        .word_wdata(word_wdata), .word_vld(word_vld), .word_err(word_err),
        .word_rdata(word_rdata),
        .pre_en(pre_en), .pre_addr(pre_addr), .pre_data(pre_data), .pre_err(pre_err)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] model_word(input int idx);
        return {model[4*idx], model[4*idx+1], model[4*idx+2], model[4*idx+3]};
    endfunction

    task automatic idle_inputs();
        fetch_en = 1'b0; word_rd = 1'b0; word_wr = 1'b0; pre_en = 1'b0;
    endtask

    task automatic do_fetch(input string tag, input int a, input logic [7:0] exp, input logic eerr);
        fetch_en = 1'b1; fetch_addr = AW'(a);
        @(negedge clk);
        idle_inputs();
        chk({tag, " vld"}, 32'(fetch_vld), 32'd1);
        chk({tag, " err"}, 32'(fetch_err), 32'(eerr));
        chk({tag, " byte"}, 32'(fetch_byte), 32'(exp));
    endtask

    task automatic do_word_rd(input string tag, input int idx, input logic [31:0] exp, input logic eerr);
        word_rd = 1'b1; word_idx = AW'(idx);
        @(negedge clk);
        idle_inputs();
        chk({tag, " vld"}, 32'(word_vld), 32'd1);
        chk({tag, " err"}, 32'(word_err), 32'(eerr));
        chk({tag, " data"}, word_rdata, exp);
    endtask

    task automatic do_word_wr(input string tag, input int idx, input logic [31:0] d, input logic eerr);
        word_wr = 1'b1; word_idx = AW'(idx); word_wdata = d;
        @(negedge clk);
        idle_inputs();
        chk({tag, " err"}, 32'(word_err), 32'(eerr));
        if (!eerr) begin
            for (int k = 0; k < 4; k++) model[4*idx+k] = d[31-8*k -: 8];
        end
    endtask

    task automatic do_pre(input string tag, input int a, input logic [7:0] d, input logic eerr);
        pre_en = 1'b1; pre_addr = AW'(a); pre_data = d;
        @(negedge clk);
        idle_inputs();
        chk({tag, " err"}, 32'(pre_err), 32'(eerr));
        if (!eerr) model[a] = d;
    endtask

    // R1 R2: reset state, sweep length, requests ignored while sweeping
    task automatic t_reset();
        int n;
        rst_n = 1'b0;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 ready low in reset", 32'(ready), 32'd0);
        chk("R1 fetch_byte reset", 32'(fetch_byte), 32'd0);
        chk("R1 word_rdata reset", word_rdata, 32'd0);
        rst_n = 1'b1;
        fetch_en = 1'b1; fetch_addr = '0;
        word_rd = 1'b1; word_idx = '0; pre_en = 1'b1; pre_addr = 8'd200;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            chk("R1 no fetch_vld during sweep", 32'(fetch_vld), 32'd0);
            chk("R1 no word_vld during sweep", 32'(word_vld), 32'd0);
            chk("R1 no pre_err during sweep", 32'(pre_err), 32'd0);
        end while (!ready && n < 40);
        idle_inputs();
        chk("R1 sweep cycles", 32'(n), 32'(ROWS));
    endtask

    // R2: untouched bytes read zero on both views
    task automatic t_zero();
        for (int a = 0; a < DEPTH; a++) do_fetch("R2 fetch zero", a, 8'h00, 1'b0);
        for (int i = 0; i < DEPTH / 4; i++) do_word_rd("R2 word zero", i, 32'h0, 1'b0);
    endtask

    // R8 R5 R4: preload then read through both views
    task automatic t_preload();
        for (int a = 0; a < 8; a++) do_pre("R8 preload", a, 8'(8'h30 + 8'(a * 17)), 1'b0);
        for (int a = 0; a < 8; a++) do_fetch("R5 fetch preloaded", a, model[a], 1'b0);
        do_word_rd("R4 word assembly idx0", 0, model_word(0), 1'b0);
        do_word_rd("R4 word assembly idx1", 1, model_word(1), 1'b0);
    endtask

    // R3 R4: big-endian word placement
    task automatic t_word();
        do_word_wr("R3 word write", 2, 32'hA1B2C3D4, 1'b0);
        do_fetch("R3 byte +0", 8, 8'hA1, 1'b0);
        do_fetch("R3 byte +1", 9, 8'hB2, 1'b0);
        do_fetch("R3 byte +2", 10, 8'hC3, 1'b0);
        do_fetch("R3 byte +3", 11, 8'hD4, 1'b0);
        do_word_rd("R4 word readback", 2, 32'hA1B2C3D4, 1'b0);
        do_word_wr("R3 word write last full", 4, 32'h0F1E2D3C, 1'b0);
        do_word_rd("R4 word readback last full", 4, 32'h0F1E2D3C, 1'b0);
    endtask

    // R6 R7 R8: out-of-range on every port
    task automatic t_range();
        do_fetch("R6 fetch at depth", DEPTH, 8'h00, 1'b1);
        do_fetch("R6 fetch far", 200, 8'h00, 1'b1);
        do_fetch("R5 fetch last byte", DEPTH - 1, 8'h00, 1'b0);
        do_pre("R8 preload byte 20", 20, 8'h5A, 1'b0);
        do_pre("R8 preload byte 21", 21, 8'h6B, 1'b0);
        do_pre("R8 preload out of range", DEPTH, 8'hFF, 1'b1);
        do_word_rd("R7 word read straddling end", 5, 32'h0, 1'b1);
        do_word_wr("R7 word write straddling end", 5, 32'hDEADBEEF, 1'b1);
        do_fetch("R7 byte 20 untouched", 20, 8'h5A, 1'b0);
        do_fetch("R7 byte 21 untouched", 21, 8'h6B, 1'b0);
        do_word_rd("R7 word idx far", 100, 32'h0, 1'b1);
    endtask

    // R9: read during write returns old contents
    task automatic t_rw_same();
        logic [31:0] old_w;
        old_w = model_word(1);
        word_rd = 1'b1; word_wr = 1'b1; word_idx = 8'd1; word_wdata = 32'h13579BDF;
        fetch_en = 1'b1; fetch_addr = 8'd6;
        @(negedge clk);
        idle_inputs();
        chk("R9 word read old", word_rdata, old_w);
        chk("R9 fetch old", 32'(fetch_byte), 32'(model[6]));
        for (int k = 0; k < 4; k++) model[4+k] = 8'(32'h13579BDF >> (24 - 8*k));
        do_word_rd("R9 word new after", 1, 32'h13579BDF, 1'b0);
    endtask

    // R10: preload dropped when a word write is accepted in the same cycle
    task automatic t_collide();
        logic [7:0] b0;
        b0 = model[0];
        pre_en = 1'b1; pre_addr = 8'd12; pre_data = 8'h77;
        word_wr = 1'b1; word_idx = 8'd3; word_wdata = 32'h11223344;
        @(negedge clk);
        idle_inputs();
        for (int k = 0; k < 4; k++) model[12+k] = 8'(32'h11223344 >> (24 - 8*k));
        do_fetch("R10 same byte word wins", 12, 8'h11, 1'b0);
        pre_en = 1'b1; pre_addr = 8'd0; pre_data = 8'hEE;
        word_wr = 1'b1; word_idx = 8'd3; word_wdata = 32'h55667788;
        @(negedge clk);
        idle_inputs();
        for (int k = 0; k < 4; k++) model[12+k] = 8'(32'h55667788 >> (24 - 8*k));
        do_fetch("R10 other row preload dropped", 0, b0, 1'b0);
        do_word_rd("R10 word stored", 3, 32'h55667788, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog expired got hang exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_zero();
        t_preload();
        t_word();
        t_range();
        t_rw_same();
        t_collide();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R11 ready held", 32'(ready), 32'd1);
        end
        t_reset();
        do_fetch("R2 cleared after re-reset byte 9", 9, 8'h00, 1'b0);
        do_word_rd("R2 cleared after re-reset idx3", 3, 32'h0, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule